// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small 16-bit single-bus processor. It keeps a 6-bit microaddress register and a 64-entry control store of 16-bit microwords whose contents are fixed at elaboration. The control store is a parameter, and by default it holds a fetch, operand and dispatch microprogram. Each microword is latched into a microinstruction register. Three encoded fields of that register are decoded into one-hot datapath strobes. A 2-bit sequencing field picks the next microaddress: a plain jump to the base field, or the base field OR-ed with the instruction's opcode or with one of its addressing modes shifted left by two. This gives multiway dispatch without a separate mapping table.

Each microstep takes two clock cycles. In the load cycle the microword at the current microaddress enters the microinstruction register and all strobes are low. In the execute cycle the strobes of that microword are driven and the next microaddress is computed. The instruction-register fields are sampled only at the clock edge that ends an execute cycle. When the sequence reaches the halt routine, the block freezes and raises a sticky halt flag.

Top module: `useq_ctrl`

## Requirements
- R1: `rst_n` low clears the block at once: every strobe is 0 and `halted` is 0. Reset release passes through a two-stage synchronizer. The first load cycle follows the second rising edge after release, so microaddress 00 drives its strobes in the cycle after the third rising edge.
- R2: A microstep is one load cycle followed by one execute cycle. In a load cycle all strobes are 0. In an execute cycle they reflect the current microword.
- R3: The microword holds the base address in bits 15..10, the bus-source code in bits 9..7, the load code in bits 6..4, the auxiliary code in bits 3..2 and the sequencing code in bits 1..0. For a nonzero code c, bit c-1 of `src_stb`, `ld_stb` or `aux_stb` is high, and only that bit. Code 0 drives none.
- R4: Sequencing code 0 sets the next microaddress to the base field.
- R5: Sequencing code 1 sets the next microaddress to base OR (`ir_src_mode` << 2).
- R6: Sequencing code 2 sets the next microaddress to base OR the zero-extended `ir_opcode`.
- R7: Sequencing code 3 sets the next microaddress to base OR (`ir_dst_mode` << 2).
- R8: The default fetch routine is fixed. Address 00 drives source 1 (PC out), load 1 (address register) and aux 1 (PC increment). Address 01 drives load 2 (data register) and aux 2 (memory read). Address 02 drives source 2 (data register out) and load 3 (instruction register). Address 03 drives no strobes and dispatches on the source mode with base 10h.
- R9: The default source routines are as follows. At 10h, register-direct drives source 7 (register read) and load 4 (Y). Register-indirect runs 14h, 15h, 16h. Step 14h drives source 7 and load 1. Step 15h drives load 2 and aux 2. Step 16h drives source 2 and load 4. Modes 2 and 3 (18h, 1Ch) drive nothing. Every final source step dispatches on the opcode with base 20h.
- R10: For opcodes 0 to 6, step 20h+op drives source 3 and load op+1, then dispatches on the destination mode with base 30h. The destination step 30h+4*mode drives source 4 and aux code equal to the mode, then jumps to 00.
- R11: Opcode 7 leads to the halt address 27h. `halted` rises at the edge that ends the dispatching execute cycle and stays high. The microaddress stays fixed, all strobes stay 0, and only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_opcode | input | 3 | Opcode field of the instruction register |
| ir_src_mode | input | 2 | Source addressing mode |
| ir_dst_mode | input | 2 | Destination addressing mode |
| src_stb | output | 7 | One-hot bus-source strobes, bit c-1 for code c |
| ld_stb | output | 7 | One-hot register-load strobes, bit c-1 for code c |
| aux_stb | output | 3 | One-hot auxiliary strobes, bit c-1 for code c |
| halted | output | 1 | Sticky halt flag |

## Verification
The strobes of every execute cycle identify the microword in use. A wrong microaddress, a wrong dispatch or a wrong field decode therefore shows as a wrong strobe pattern in the very next execute cycle, two clock cycles after the faulty edge. A microinstruction register that loads in the wrong phase shows as nonzero strobes in a load cycle. A halt flag that is wrong shows one cycle after the dispatch into the halt address, and it stays visible for as long as the block is frozen.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W     = 6;
  localparam int F1_W     = 3;
  localparam int F2_W     = 3;
  localparam int F3_W     = 2;
  localparam int SEL_W    = 2;
  localparam int OP_W     = 3;
  localparam int MODE_W   = 2;
  localparam int MODE_SH  = 2;
  localparam int UW       = UA_W + F1_W + F2_W + F3_W + SEL_W;
  localparam int UC_DEPTH = 1 << UA_W;
  localparam int UC_BITS  = UC_DEPTH * UW;
  localparam int F1_N     = (1 << F1_W) - 1;
  localparam int F2_N     = (1 << F2_W) - 1;
  localparam int F3_N     = (1 << F3_W) - 1;

  typedef enum logic [SEL_W-1:0] {
    SEQ_JUMP = 2'd0,
    SEQ_SRC  = 2'd1,
    SEQ_OP   = 2'd2,
    SEQ_DST  = 2'd3
  } seq_e;

  typedef struct packed {
    logic [UA_W-1:0] nxt_base;
    logic [F1_W-1:0] bus_src;
    logic [F2_W-1:0] load_dst;
    logic [F3_W-1:0] aux;
    seq_e            seq_sel;
  } uword_t;

  typedef enum logic {PH_LOAD = 1'b0, PH_EXEC = 1'b1} phase_e;

  function automatic uword_t mk(input logic [UA_W-1:0] base, input logic [F1_W-1:0] s,
                                input logic [F2_W-1:0] l, input logic [F3_W-1:0] x,
                                input seq_e sel);
    uword_t w;
    w.nxt_base = base;
    w.bus_src  = s;
    w.load_dst = l;
    w.aux      = x;
    w.seq_sel  = sel;
    return w;
  endfunction

  // Default microprogram: fetch, operand fetch, opcode step, destination step, halt
  function automatic uword_t ucode_word(input logic [UA_W-1:0] a);
    uword_t w;
    w = '0;
    case (a)
      6'h00: w = mk(6'h01, 3'd1, 3'd1, 2'd1, SEQ_JUMP);
      6'h01: w = mk(6'h02, 3'd0, 3'd2, 2'd2, SEQ_JUMP);
      6'h02: w = mk(6'h03, 3'd2, 3'd3, 2'd0, SEQ_JUMP);
      6'h03: w = mk(6'h10, 3'd0, 3'd0, 2'd0, SEQ_SRC);
      6'h10: w = mk(6'h20, 3'd7, 3'd4, 2'd0, SEQ_OP);
      6'h14: w = mk(6'h15, 3'd7, 3'd1, 2'd0, SEQ_JUMP);
      6'h15: w = mk(6'h16, 3'd0, 3'd2, 2'd2, SEQ_JUMP);
      6'h16: w = mk(6'h20, 3'd2, 3'd4, 2'd0, SEQ_OP);
      6'h18, 6'h1C: w = mk(6'h20, 3'd0, 3'd0, 2'd0, SEQ_OP);
      6'h27: w = mk(6'h27, 3'd0, 3'd0, 2'd0, SEQ_JUMP);
      6'h30, 6'h34, 6'h38, 6'h3C: w = mk(6'h00, 3'd4, 3'd0, a[3:2], SEQ_JUMP);
      default: begin
        if (a >= 6'h20 && a <= 6'h26) w = mk(6'h30, 3'd3, a[2:0] + 3'd1, 2'd0, SEQ_DST);
      end
    endcase
    return w;
  endfunction

  function automatic logic [UC_BITS-1:0] build_ucode();
    logic [UC_BITS-1:0] img;
    img = '0;
    for (int a = 0; a < UC_DEPTH; a++) img[a*UW +: UW] = ucode_word(UA_W'(a));
    return img;
  endfunction

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter logic [UC_BITS-1:0] UCODE = build_ucode()
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [UA_W-1:0] addr,
  output uword_t          uir
);
  uword_t rd_word;
  uword_t uir_d;

  always_comb begin
    rd_word = uword_t'(UCODE[int'(addr)*UW +: UW]);
    uir_d   = load_en ? rd_word : uir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uir <= '0;
    else        uir <= uir_d;
  end
endmodule

// File: rtl/useq_field_dec.sv
module useq_field_dec #(
  parameter int W = 3,
  localparam int N = (1 << W) - 1
) (
  input  logic         en,
  input  logic [W-1:0] code,
  output logic [N-1:0] stb
);
  for (genvar i = 1; i <= N; i++) begin : g_line
    assign stb[i-1] = en && (code == W'(i));
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic [UA_W-1:0]   base,
  input  seq_e              sel,
  input  logic [OP_W-1:0]   opcode,
  input  logic [MODE_W-1:0] src_mode,
  input  logic [MODE_W-1:0] dst_mode,
  output logic [UA_W-1:0]   nxt
);
  always_comb begin
    case (sel)
      SEQ_SRC: nxt = base | (UA_W'(src_mode) << MODE_SH);
      SEQ_OP:  nxt = base | UA_W'(opcode);
      SEQ_DST: nxt = base | (UA_W'(dst_mode) << MODE_SH);
      default: nxt = base;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter logic [UA_W-1:0]    HALT_ADDR = 6'h27,
  parameter logic [UC_BITS-1:0] UCODE     = build_ucode()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   ir_opcode,
  input  logic [MODE_W-1:0] ir_src_mode,
  input  logic [MODE_W-1:0] ir_dst_mode,
  output logic [F1_N-1:0]   src_stb,
  output logic [F2_N-1:0]   ld_stb,
  output logic [F3_N-1:0]   aux_stb,
  output logic              halted
);
  logic            rst_sn;
  logic [UA_W-1:0] uar_q, uar_d, nxt_addr;
  phase_e          phase_q, phase_d;
  logic            halt_q, halt_d;
  logic            uir_load, stb_en;
  uword_t          uir_q;

  useq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sn)
  );

  useq_store #(.UCODE(UCODE)) u_store (
    .clk(clk), .rst_n(rst_sn), .load_en(uir_load), .addr(uar_q), .uir(uir_q)
  );

  useq_next_addr u_next (
    .base(uir_q.nxt_base), .sel(uir_q.seq_sel), .opcode(ir_opcode),
    .src_mode(ir_src_mode), .dst_mode(ir_dst_mode), .nxt(nxt_addr)
  );

  useq_field_dec #(.W(F1_W)) u_dec_src (.en(stb_en), .code(uir_q.bus_src),  .stb(src_stb));
  useq_field_dec #(.W(F2_W)) u_dec_ld  (.en(stb_en), .code(uir_q.load_dst), .stb(ld_stb));
  useq_field_dec #(.W(F3_W)) u_dec_aux (.en(stb_en), .code(uir_q.aux),      .stb(aux_stb));

  always_comb begin
    uir_load = !halt_q && (phase_q == PH_LOAD);
    stb_en   = !halt_q && (phase_q == PH_EXEC);
    uar_d    = uar_q;
    phase_d  = phase_q;
    halt_d   = halt_q;
    if (!halt_q) begin
      if (phase_q == PH_LOAD) begin
        phase_d = PH_EXEC;
      end else begin
        phase_d = PH_LOAD;
        uar_d   = nxt_addr;
        if (nxt_addr == HALT_ADDR) halt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      uar_q   <= '0;
      phase_q <= PH_LOAD;
      halt_q  <= 1'b0;
    end else begin
      uar_q   <= uar_d;
      phase_q <= phase_d;
      halt_q  <= halt_d;
    end
  end

  assign halted = halt_q;

  // R2: the microaddress moves only at the end of an execute cycle
  p_uar_hold_load_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == PH_LOAD) |=> $stable(uar_q));

  // R2: the microinstruction register holds through its execute cycle
  p_uir_hold_exec_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == PH_EXEC) |=> $stable(uir_q));

  // R3: at most one strobe per field
  p_one_src_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(src_stb) && $onehot0(ld_stb) && $onehot0(aux_stb));

  // R4: every dispatch keeps all base bits set
  p_base_kept_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == PH_EXEC && !halt_q) |=> ((uar_q & $past(uir_q.nxt_base)) == $past(uir_q.nxt_base)));

  // R5: a mode dispatch leaves the two low bits equal to the base
  p_src_low_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == PH_EXEC && !halt_q && uir_q.seq_sel == SEQ_SRC) |=> (uar_q[1:0] == $past(uir_q.nxt_base[1:0])));

  // R11: halt is sticky and freezes the microaddress at the halt address
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    halt_q |=> (halt_q && $stable(uar_q)));

  p_halt_addr_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    halt_q |-> (uar_q == HALT_ADDR && src_stb == '0 && ld_stb == '0 && aux_stb == '0));

endmodule

// File: tb/useq_ctrl_bench.sv
`timescale 1ns/1ps
module useq_ctrl_bench;

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] sm;
    logic [1:0] dm;
    logic [7:0] codes;
    logic [5:0] ua;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ir_op = '0;
  logic [1:0] ir_sm = '0;
  logic [1:0] ir_dm = '0;
  logic [6:0] src_stb, ld_stb;
  logic [2:0] aux_stb;
  logic       halted;
  int         n_vec = 0;
  int         n_bad = 0;
  int         ecnt;
  item_t      q[$];
  item_t      mon_it;

  useq_ctrl u_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .ir_opcode(ir_op), .ir_src_mode(ir_sm),
    .ir_dst_mode(ir_dm), .src_stb(src_stb), .ld_stb(ld_stb),
    .aux_stb(aux_stb), .halted(halted)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected field codes {src[2:0], load[2:0], aux[1:0]} per address (R8, R9, R10)
  function automatic logic [7:0] spec_codes(input logic [5:0] ua);
    logic [7:0] c;
    c = '0;
    case (ua)
      6'h00: c = {3'd1, 3'd1, 2'd1};
      6'h01: c = {3'd0, 3'd2, 2'd2};
      6'h02: c = {3'd2, 3'd3, 2'd0};
      6'h10: c = {3'd7, 3'd4, 2'd0};
      6'h14: c = {3'd7, 3'd1, 2'd0};
      6'h15: c = {3'd0, 3'd2, 2'd2};
      6'h16: c = {3'd2, 3'd4, 2'd0};
      6'h30, 6'h34, 6'h38, 6'h3C: c = {3'd4, 3'd0, ua[3:2]};
      default: if (ua >= 6'h20 && ua <= 6'h26) c = {3'd3, ua[2:0] + 3'd1, 2'd0};
    endcase
    return c;
  endfunction

  function automatic logic [16:0] expand(input logic [7:0] c);
    logic [6:0] s, l;
    logic [2:0] x;
    s = (c[7:5] == 0) ? 7'd0 : 7'd1 << (c[7:5] - 3'd1);
    l = (c[4:2] == 0) ? 7'd0 : 7'd1 << (c[4:2] - 3'd1);
    x = (c[1:0] == 0) ? 3'd0 : 3'd1 << (c[1:0] - 2'd1);
    return {s, l, x};
  endfunction

  function automatic string tag_of(input logic [5:0] ua);
    if (ua == 6'h00)      return "R1 R3 R4 R8 fetch start";
    else if (ua < 6'h04)  return "R3 R4 R8 fetch";
    else if (ua < 6'h20)  return "R3 R5 R9 source step";
    else if (ua < 6'h30)  return "R3 R6 R10 opcode step";
    else                  return "R3 R7 R10 destination step";
  endfunction

  task automatic push_step(input logic [5:0] ua, input logic [2:0] op,
                           input logic [1:0] sm, input logic [1:0] dm);
    item_t it;
    it.op = op; it.sm = sm; it.dm = dm; it.ua = ua; it.codes = spec_codes(ua);
    q.push_back(it);
  endtask

  // Driver: expected microstep path of one instruction
  task automatic push_instr(input logic [2:0] op, input logic [1:0] sm, input logic [1:0] dm);
    for (int a = 0; a < 4; a++) push_step(6'(a), op, sm, dm);
    case (sm)
      2'd0: push_step(6'h10, op, sm, dm);
      2'd1: begin
        push_step(6'h14, op, sm, dm);
        push_step(6'h15, op, sm, dm);
        push_step(6'h16, op, sm, dm);
      end
      2'd2: push_step(6'h18, op, sm, dm);
      default: push_step(6'h1C, op, sm, dm);
    endcase
    if (op != 3'd7) begin
      push_step(6'h20 | 6'(op), op, sm, dm);
      push_step(6'h30 | {2'b00, dm, 2'b00}, op, sm, dm);
    end
  endtask

  // Monitor: pops expected items in execute cycles, checks idle load cycles
  always @(negedge clk) begin
    if (rst_n && ecnt >= 3) begin
      if (ecnt[0]) begin
        if (q.size() > 0) begin
          mon_it = q.pop_front();
          chk($sformatf("%s ua %0h", tag_of(mon_it.ua), mon_it.ua),
              {15'd0, src_stb, ld_stb, aux_stb}, {15'd0, expand(mon_it.codes)});
          chk("R11 halted low while running", {31'd0, halted}, 32'd0);
          ir_op = mon_it.op;
          ir_sm = mon_it.sm;
          ir_dm = mon_it.dm;
        end
      end else begin
        chk("R2 strobes idle in load cycle", {15'd0, src_stb, ld_stb, aux_stb}, 32'd0);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic check_halt_hold();
    wait (q.size() == 0);
    @(negedge clk);
    chk("R11 halted rises after dispatch to halt", {31'd0, halted}, 32'd1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R11 halted sticky", {31'd0, halted}, 32'd1);
      chk("R11 strobes zero when halted", {15'd0, src_stb, ld_stb, aux_stb}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // Phase A: reset state, full program, halt on direct source
    #5;
    chk("R1 strobes zero in reset", {15'd0, src_stb, ld_stb, aux_stb}, 32'd0);
    chk("R1 halted low in reset", {31'd0, halted}, 32'd0);
    push_instr(3'd0, 2'd0, 2'd0);
    push_instr(3'd1, 2'd1, 2'd1);
    push_instr(3'd2, 2'd2, 2'd2);
    push_instr(3'd3, 2'd3, 2'd3);
    push_instr(3'd4, 2'd0, 2'd1);
    push_instr(3'd5, 2'd1, 2'd2);
    push_instr(3'd6, 2'd0, 2'd3);
    push_instr(3'd7, 2'd0, 2'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle before first load", {15'd0, src_stb, ld_stb, aux_stb}, 32'd0);
    check_halt_hold();

    // Phase B: reset clears halt, second program halts via indirect source
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 R11 reset clears halted", {31'd0, halted}, 32'd0);
    chk("R1 strobes zero after reset", {15'd0, src_stb, ld_stb, aux_stb}, 32'd0);
    push_instr(3'd6, 2'd2, 2'd0);
    push_instr(3'd7, 2'd1, 2'd3);
    @(negedge clk);
    rst_n = 1'b1;
    check_halt_hold();

    // Phase C: asynchronous reset in the middle of an execute cycle
    @(negedge clk);
    rst_n = 1'b0;
    push_instr(3'd3, 2'd1, 2'd2);
    @(negedge clk);
    rst_n = 1'b1;
    wait (ecnt == 5);
    #5;
    chk("R1 ua 1 strobes active before reset", {15'd0, src_stb, ld_stb, aux_stb},
        {15'd0, expand(spec_codes(6'h01))});
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears strobes", {15'd0, src_stb, ld_stb, aux_stb}, 32'd0);
    chk("R1 async reset halted low", {31'd0, halted}, 32'd0);
    q.delete();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule